// File: doc/BRIEF.md
# Cascadable presettable synchronous counter

This block is a small binary counter stage, four bits wide by default, that can be preset or cleared. Software-free control logic drives it through a handful of plain control pins. An active-low load strobe copies a preset word into the count on the next rising clock edge. An active-low reset clears the count and wins over every other control. A compile-time parameter decides whether that reset acts at once or waits for a rising edge.

Counting uses two enables. The local enable is usually shared by every stage of a chain. The chain enable is fed by the stage below. The count advances only when both are high. The terminal-count flag is high when the count is all ones and the chain enable is high. The local enable has no part in it.

To build a wider counter, connect one stage's terminal-count flag to the next stage's chain enable. Because the flag is combinational, the carry reaches the next stage within the same cycle. The block has no streaming data path, so it has no valid/ready handshake; every pin is a plain level.

Top module: `casc_counter`

## Requirements
- R1: While reset is applied and after it is released with no other activity, count_q is 0 and term_cnt is 0.
- R2: When load_n is low and reset is inactive, the rising edge writes preset_val into count_q, whatever the levels of en_local and en_chain.
- R3: Reset wins over a load and over both enables: with rst_n low, load_n low and both enables high, count_q becomes 0 rather than preset_val or an incremented value.
- R4: When load_n is high and en_local and en_chain are both high, each rising edge adds one to count_q, and the all-ones value wraps to 0. For example, a preset of 12 is followed by 13, 14, 15, 0, 1, 2.
- R5: When load_n is high and either en_local or en_chain is low, count_q keeps its value across rising edges.
- R6: term_cnt is 1 exactly when en_chain is 1 and count_q is all ones. It follows en_chain in the same cycle without waiting for a clock edge, and en_local has no effect on it.
- R7: With ASYNC_RST = 1, a low on rst_n clears count_q at once, before any clock edge.
- R8: With ASYNC_RST = 0, a low on rst_n leaves count_q unchanged until the next rising edge, which clears it.
- R9: Two stages chained by feeding the lower term_cnt into the upper en_chain, with en_local shared and the lower en_chain held high, form an 8-bit counter. After n counting edges from zero, the lower stage reads n mod 16 and the upper stage reads (n / 16) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counting and loading happen on its rising edge |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous according to ASYNC_RST |
| load_n | input | 1 | Active-low parallel load strobe |
| en_local | input | 1 | Local count enable; usually shared by all stages of a chain |
| en_chain | input | 1 | Chain count enable; also gates term_cnt |
| preset_val | input | WIDTH | Word that a load copies into the count |
| count_q | output | WIDTH | Current count |
| term_cnt | output | 1 | High when en_chain is high and the count is all ones |

## Verification
On every clock cycle, the assertions check the next count for each operation: a load takes the preset, counting adds one, and a disabled stage holds. They also check that term_cnt never rises without en_chain and an all-ones count, and that the chosen reset style clears the count. Some behaviour only the bench scenarios can show: that the asynchronous variant clears between clock edges while the synchronous one waits for the edge; that term_cnt drops within the same cycle when en_chain falls and ignores en_local; and that a two-stage chain carries exactly once per sixteen lower counts, including the wrap of the full 8-bit value.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_t;

endpackage

// File: rtl/casc_counter_ctrl.sv
module casc_counter_ctrl
  import casc_counter_pkg::*;
(
  input  logic    load_n,
  input  logic    en_local,
  input  logic    en_chain,
  output cnt_op_t op
);

  // Load outranks counting; reset is handled in the register itself.
  always_comb begin
    if (!load_n)                     op = OP_LOAD;
    else if (en_local && en_chain)   op = OP_COUNT;
    else                             op = OP_HOLD;
  end

endmodule

// File: rtl/casc_counter_reg.sv
module casc_counter_reg
  import casc_counter_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_t          op,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count_q
);

  logic [WIDTH-1:0] count_d;

  always_comb begin
    case (op)
      OP_LOAD:  count_d = preset_val;
      OP_COUNT: count_d = count_q + WIDTH'(1);
      default:  count_d = count_q;
    endcase
  end

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
      end

      // R7
      async_clear_chk: assert property (@(posedge clk)
        !rst_n |-> count_q == '0);
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
      end

      // R8
      sync_clear_chk: assert property (@(posedge clk)
        !rst_n |=> count_q == '0);
    end
  endgenerate

endmodule

// File: rtl/casc_counter_tc.sv
module casc_counter_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_q,
  input  logic             en_chain,
  output logic             term_cnt
);

  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  assign term_cnt = en_chain && (count_q == TOP_VAL);

endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_counter_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             en_local,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count_q,
  output logic             term_cnt
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  cnt_op_t op;

  casc_counter_ctrl ctrl_i (
    .load_n   (load_n),
    .en_local (en_local),
    .en_chain (en_chain),
    .op       (op)
  );

  casc_counter_reg #(
    .WIDTH     (WIDTH),
    .ASYNC_RST (ASYNC_RST)
  ) reg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .preset_val (preset_val),
    .count_q    (count_q)
  );

  casc_counter_tc #(
    .WIDTH (WIDTH)
  ) tc_i (
    .count_q  (count_q),
    .en_chain (en_chain),
    .term_cnt (term_cnt)
  );

  // R2
  load_takes_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count_q == $past(preset_val));

  // R4
  count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_local && en_chain) |=> count_q == $past(count_q) + WIDTH'(1));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_local && en_chain)) |=> $stable(count_q));

  // R6
  tc_needs_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_chain |-> !term_cnt);

  // R6
  tc_needs_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> count_q == ALL_ONES);

endmodule

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         load_n = 1'b1;
  logic         en_local = 1'b0;
  logic         en_chain = 1'b0;
  logic [W-1:0] preset_val = '0;

  logic [W-1:0] cnt_lo, cnt_up, cnt_sy;
  logic         tc_lo, tc_up, tc_sy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  casc_counter #(.WIDTH(W), .ASYNC_RST(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_local(en_local),
    .en_chain(en_chain), .preset_val(preset_val),
    .count_q(cnt_lo), .term_cnt(tc_lo)
  );

  casc_counter #(.WIDTH(W), .ASYNC_RST(1'b1)) upper_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_local(en_local),
    .en_chain(tc_lo), .preset_val(preset_val),
    .count_q(cnt_up), .term_cnt(tc_up)
  );

  casc_counter #(.WIDTH(W), .ASYNC_RST(1'b0)) sync_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_local(en_local),
    .en_chain(en_chain), .preset_val(preset_val),
    .count_q(cnt_sy), .term_cnt(tc_sy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #2 rst_n = 1'b0;
    en_local = 1'b1;
    en_chain = 1'b1;
    step();
    step();
    check("R1", "async count in reset", cnt_lo, 0);
    check("R1", "sync count in reset", cnt_sy, 0);
    check("R1", "term_cnt in reset", tc_lo, 0);
    en_local = 1'b0;
    en_chain = 1'b0;
    rst_n = 1'b1;
    step();
    check("R1", "count after release", cnt_lo, 0);
    check("R1", "term_cnt after release", tc_lo, 0);
  endtask

  task automatic t_load();
    load_n = 1'b0;
    preset_val = 4'd12;
    en_local = 1'b1;
    en_chain = 1'b1;
    step();
    check("R2", "load with enables high", cnt_lo, 12);
    check("R2", "sync stage load", cnt_sy, 12);
  endtask

  task automatic t_count_wrap();
    int exp_seq[6] = '{13, 14, 15, 0, 1, 2};
    load_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      check("R4", "count sequence", cnt_lo, exp_seq[i]);
      check("R6", "term_cnt while counting", tc_lo, (exp_seq[i] == 15) ? 1 : 0);
    end
  endtask

  task automatic t_hold();
    en_local = 1'b0;
    en_chain = 1'b1;
    for (int i = 0; i < 3; i++) step();
    check("R5", "hold with en_local low", cnt_lo, 2);
    en_local = 1'b1;
    en_chain = 1'b0;
    step();
    step();
    check("R5", "hold with en_chain low", cnt_lo, 2);
  endtask

  task automatic t_tc_gating();
    load_n = 1'b0;
    preset_val = 4'd15;
    step();
    load_n = 1'b1;
    en_local = 1'b0;
    en_chain = 1'b1;
    #1;
    check("R6", "term_cnt ignores en_local", tc_lo, 1);
    en_chain = 1'b0;
    #1;
    check("R6", "term_cnt drops with en_chain same cycle", tc_lo, 0);
    en_chain = 1'b1;
    #1;
    check("R6", "term_cnt returns with en_chain", tc_lo, 1);
    en_chain = 1'b0;
    step();
    check("R5", "count held at top", cnt_lo, 15);
  endtask

  task automatic t_reset_priority();
    load_n = 1'b0;
    preset_val = 4'd9;
    en_local = 1'b1;
    en_chain = 1'b1;
    rst_n = 1'b0;
    step();
    check("R3", "reset over load, async", cnt_lo, 0);
    check("R3", "reset over load, sync", cnt_sy, 0);
    rst_n = 1'b1;
    load_n = 1'b1;
    en_local = 1'b0;
    en_chain = 1'b0;
    step();
  endtask

  task automatic t_reset_modes();
    load_n = 1'b0;
    preset_val = 4'd7;
    step();
    load_n = 1'b1;
    check("R2", "preset 7 before reset", cnt_sy, 7);
    #2 rst_n = 1'b0;
    #1;
    check("R7", "async clears without edge", cnt_lo, 0);
    check("R8", "sync waits for edge", cnt_sy, 7);
    step();
    check("R8", "sync clears at edge", cnt_sy, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_cascade();
    en_local = 1'b1;
    en_chain = 1'b1;
    for (int n = 1; n <= 300; n++) begin
      step();
      check("R9", "lower stage", cnt_lo, n % 16);
      check("R9", "upper stage", cnt_up, (n / 16) % 16);
    end
    en_local = 1'b0;
  endtask

  initial begin
    t_reset();
    t_load();
    t_count_wrap();
    t_hold();
    t_tc_gating();
    t_reset_priority();
    t_reset_modes();
    t_cascade();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule